// File: doc/BRIEF.md
# UART Transmit Buffer Controller

This block sits between a host register interface and a UART serializer. It takes the characters the host writes and decides where each one goes: straight into the serializer's shift register when the transmitter is idle, into a transmit queue when queue mode is on, or into a single holding register when it is off. Each time the serializer reports that a character has been shifted out, the block hands it the next one. It also keeps two status flags: transmitter-empty and data-request.

Data-request tracks a half-full mark in queue mode, not queue-empty. It drops when the queue holds more than half its depth. It comes back after a shift-out leaves half the depth or fewer. Releasing the send-break control puts a break marker character through the same path as a host write. That marker is a 9-bit character with bit 8 set and the low byte zero. A transmit reset returns the flags to their idle state and discards everything queued. The same reset is used when the unit is enabled.

Top module: `uart_txbuf`

## Requirements
- R1: A synchronous reset or a `tx_clr` pulse leaves `tx_empty`=1, `data_req`=1 and `shift_load`=0 on the next cycle, and empties the queue.
- R2: A character written while `tx_empty`=1 is loaded into the shift register: on the next cycle `shift_load`=1, `shift_data` holds the character with bit 8 = 0, and `tx_empty`=0.
- R3: In queue mode (`fifo_mode`=1), a character written while the shift register is busy is queued. `data_req` clears when the queue then holds more than DEPTH/2 (32 by default) characters.
- R4: In queue mode, a character written while the queue holds DEPTH characters is dropped silently: it is never delivered to the shift register and no flag changes.
- R5: In holding mode (`fifo_mode`=0) with the shift register busy, a write while `data_req`=1 is stored in the holding register and clears `data_req`. A write while `data_req`=0 is ignored.
- R6: On `shift_done` in queue mode, the oldest queued character is loaded (`shift_load`=1 next cycle), and `data_req` is set if DEPTH/2 or fewer remain. If the queue was empty, `tx_empty` is set instead.
- R7: On `shift_done` in holding mode, a pending holding character is loaded and `data_req` is set. If nothing is pending (`data_req`=1), `tx_empty` is set.
- R8: When `shift_done` and a write occur in the same cycle, the shift completion is handled first, and the write then sees the updated state.
- R9: A falling edge of `brk_ctl` is treated as a write of the break marker 9'h100. A data write in the same cycle is dropped.
- R10: `shift_done` while `tx_empty`=1 has no effect.
- R11: `tx_clr` has priority over a write, a break or `shift_done` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_mode | input | 1 | 1 = queue mode, 0 = single holding register |
| tx_clr | input | 1 | Transmit reset / unit enable pulse |
| wr_en | input | 1 | Host data write strobe |
| wr_data | input | DATA_W | Host data byte |
| brk_ctl | input | 1 | Send-break control level; a falling edge enqueues the break marker |
| shift_done | input | 1 | Serializer finished shifting the current character |
| shift_load | output | 1 | Shift register loaded this cycle (registered pulse) |
| shift_data | output | DATA_W+1 | Character in the shift register; bit DATA_W marks a break |
| tx_empty | output | 1 | Transmitter empty |
| data_req | output | 1 | Transmitter data request |

## Verification
The assertions rely on two conditions. First, `fifo_mode` changes only in a cycle where `tx_clr` is also asserted. Second, `shift_done` is meaningful only while a character is in the shift register. The design tolerates a stray `shift_done` (R10), but the queue occupancy checks assume the controller never pops when the queue is empty. The stimulus switches mode only together with `tx_clr`. It drives `shift_done` freely, including while idle, so the ignore path is covered. Reference results come from a queue-based model that steps once per clock.

// File: rtl/uart_txbuf_pkg.sv
package uart_txbuf_pkg;
  // Where the shift register got its character from in a given cycle
  typedef enum logic [1:0] {
    LD_NONE  = 2'd0,
    LD_WRITE = 2'd1,
    LD_QUEUE = 2'd2,
    LD_HOLD  = 2'd3
  } load_src_e;

  // Break marker: flag bit above the data byte, data zero
  function automatic logic [15:0] break_marker(input int data_w);
    logic [15:0] v;
    v = '0;
    v[data_w] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/uart_txbuf_fifo.sv
module uart_txbuf_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 64
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         push,
  input  logic [W-1:0]                 push_data,
  input  logic                         pop,
  output logic [W-1:0]                 head_data,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;

  // Storage has no reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push && !clr) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign head_data = mem[rd_ptr];
  assign level     = cnt;

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_W'(DEPTH) && !pop && !clr) |-> !push);
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) |-> !pop);
  assert_level_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH));
endmodule

// File: rtl/uart_txbuf_brk.sv
module uart_txbuf_brk (
  input  logic clk,
  input  logic rst,
  input  logic brk_ctl,
  output logic brk_fell
);
  logic brk_q;

  always_ff @(posedge clk) begin
    if (rst) brk_q <= 1'b0;
    else     brk_q <= brk_ctl;
  end

  assign brk_fell = brk_q && !brk_ctl;

  assert_break_edge_R9: assert property (@(posedge clk) disable iff (rst)
    brk_fell |=> !brk_fell);
endmodule

// File: rtl/uart_txbuf_ctrl.sv
module uart_txbuf_ctrl
  import uart_txbuf_pkg::*;
#(
  parameter int CW    = 9,
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       fifo_mode,
  input  logic                       tx_clr,
  input  logic                       chr_vld,
  input  logic [CW-1:0]              chr,
  input  logic                       shift_done,
  input  logic [$clog2(DEPTH+1)-1:0] level,
  input  logic [CW-1:0]              head_data,
  output logic                       q_push,
  output logic                       q_pop,
  output logic                       shift_load,
  output logic [CW-1:0]              shift_data,
  output logic                       tx_empty,
  output logic                       data_req
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int HALF  = DEPTH / 2;
  localparam logic [CNT_W-1:0] HALF_C  = CNT_W'(HALF);
  localparam logic [CNT_W-1:0] HALF1_C = CNT_W'(HALF + 1);
  localparam logic [CNT_W-1:0] FULL_C  = CNT_W'(DEPTH);

  logic            empty_q, dreq_q, load_q;
  logic [CW-1:0]   shift_q, hold_q;
  logic            n_empty, n_dreq;
  logic [CW-1:0]   n_shift, n_hold;
  logic [CNT_W-1:0] lvl_after;
  load_src_e       src;

  always_comb begin
    n_empty   = empty_q;
    n_dreq    = dreq_q;
    n_shift   = shift_q;
    n_hold    = hold_q;
    q_push    = 1'b0;
    q_pop     = 1'b0;
    src       = LD_NONE;
    lvl_after = level;
    if (tx_clr) begin
      n_empty = 1'b1;
      n_dreq  = 1'b1;
    end else begin
      // shift completion first
      if (shift_done && !empty_q) begin
        if (fifo_mode) begin
          if (level != '0) begin
            q_pop     = 1'b1;
            src       = LD_QUEUE;
            n_shift   = head_data;
            lvl_after = level - 1'b1;
            if (level <= HALF1_C) n_dreq = 1'b1;
          end else begin
            n_empty = 1'b1;
          end
        end else if (!dreq_q) begin
          src     = LD_HOLD;
          n_shift = hold_q;
          n_dreq  = 1'b1;
        end else begin
          n_empty = 1'b1;
        end
      end
      // then the new character
      if (chr_vld) begin
        if (n_empty) begin
          src     = LD_WRITE;
          n_shift = chr;
          n_empty = 1'b0;
        end else if (fifo_mode) begin
          if (lvl_after < FULL_C) begin
            q_push = 1'b1;
            if (lvl_after >= HALF_C) n_dreq = 1'b0;
          end
        end else if (n_dreq) begin
          n_hold = chr;
          n_dreq = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      empty_q <= 1'b1;
      dreq_q  <= 1'b1;
      load_q  <= 1'b0;
      shift_q <= '0;
      hold_q  <= '0;
    end else begin
      empty_q <= n_empty;
      dreq_q  <= n_dreq;
      load_q  <= (src != LD_NONE);
      shift_q <= n_shift;
      hold_q  <= n_hold;
    end
  end

  assign shift_load = load_q;
  assign shift_data = shift_q;
  assign tx_empty   = empty_q;
  assign data_req   = dreq_q;

  assert_clear_state_R1: assert property (@(posedge clk) disable iff (rst)
    tx_clr |=> (tx_empty && data_req && !shift_load));
  assert_load_busy_R2: assert property (@(posedge clk) disable iff (rst)
    shift_load |-> !tx_empty);
  assert_hold_ignore_R5: assert property (@(posedge clk) disable iff (rst)
    (!fifo_mode && !tx_clr && !tx_empty && !data_req && chr_vld && !shift_done)
      |=> (!data_req && !shift_load));
  assert_drain_empty_R6: assert property (@(posedge clk) disable iff (rst)
    (fifo_mode && !tx_clr && !tx_empty && shift_done && level == '0 && !chr_vld)
      |=> (tx_empty && !shift_load));
  assert_idle_done_R10: assert property (@(posedge clk) disable iff (rst)
    (tx_empty && !chr_vld && !tx_clr) |=> (tx_empty && !shift_load));
endmodule

// File: rtl/uart_txbuf.sv
module uart_txbuf
  import uart_txbuf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_mode,
  input  logic              tx_clr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              brk_ctl,
  input  logic              shift_done,
  output logic              shift_load,
  output logic [DATA_W:0]   shift_data,
  output logic              tx_empty,
  output logic              data_req
);
  localparam int CW    = DATA_W + 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [15:0] BRK16 = break_marker(DATA_W);
  localparam logic [CW-1:0] BRK_CHR = BRK16[CW-1:0];

  logic            brk_fell, chr_vld, q_push, q_pop;
  logic [CW-1:0]   chr, head_data;
  logic [CNT_W-1:0] level;

  uart_txbuf_brk u_brk (
    .clk      (clk),
    .rst      (rst),
    .brk_ctl  (brk_ctl),
    .brk_fell (brk_fell)
  );

  assign chr_vld = wr_en || brk_fell;
  assign chr     = brk_fell ? BRK_CHR : {1'b0, wr_data};

  uart_txbuf_fifo #(.W(CW), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .clr       (tx_clr),
    .push      (q_push),
    .push_data (chr),
    .pop       (q_pop),
    .head_data (head_data),
    .level     (level)
  );

  uart_txbuf_ctrl #(.CW(CW), .DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .fifo_mode  (fifo_mode),
    .tx_clr     (tx_clr),
    .chr_vld    (chr_vld),
    .chr        (chr),
    .shift_done (shift_done),
    .level      (level),
    .head_data  (head_data),
    .q_push     (q_push),
    .q_pop      (q_pop),
    .shift_load (shift_load),
    .shift_data (shift_data),
    .tx_empty   (tx_empty),
    .data_req   (data_req)
  );
endmodule

// File: tb/uart_txbuf_tb.sv
module uart_txbuf_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 64;
  localparam int HALF   = DEPTH / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fifo_mode = 1'b0, tx_clr = 1'b0, wr_en = 1'b0, brk_ctl = 1'b0, shift_done = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic shift_load, tx_empty, data_req;
  logic [DATA_W:0] shift_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_txbuf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .fifo_mode(fifo_mode), .tx_clr(tx_clr),
    .wr_en(wr_en), .wr_data(wr_data), .brk_ctl(brk_ctl),
    .shift_done(shift_done), .shift_load(shift_load),
    .shift_data(shift_data), .tx_empty(tx_empty), .data_req(data_req)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit armed = 0, finished = 0;

  // behavioural reference
  int q[$];
  int m_hold = 0, m_data = 0;
  bit m_empty = 1, m_dreq = 1, m_load = 0, prevb = 0;
  string tag = "R1";

  always @(posedge clk) begin
    bit fell, chv;
    int cv;
    cyc++;
    armed = 1;
    m_load = 0;
    if (rst) begin
      q.delete(); m_empty = 1; m_dreq = 1; prevb = 0; tag = "R1";
    end else begin
      fell = prevb && !brk_ctl;
      prevb = brk_ctl;
      chv = fell || wr_en;
      cv = fell ? 256 : int'(wr_data);
      if (tx_clr) begin
        q.delete(); m_empty = 1; m_dreq = 1;
        tag = (wr_en || shift_done || fell) ? "R11" : "R1";
      end else begin
        if (shift_done && !m_empty) begin
          if (fifo_mode) begin
            tag = "R6";
            if (q.size() > 0) begin
              m_data = q.pop_front(); m_load = 1;
              if (q.size() <= HALF) m_dreq = 1;
            end else m_empty = 1;
          end else begin
            tag = "R7";
            if (!m_dreq) begin m_data = m_hold; m_load = 1; m_dreq = 1; end
            else m_empty = 1;
          end
        end else if (shift_done) tag = "R10";
        if (chv) begin
          if (fell) tag = "R9";
          else if (shift_done) tag = "R8";
          if (m_empty) begin
            m_data = cv; m_load = 1; m_empty = 0;
            if (!fell && !shift_done) tag = "R2";
          end else if (fifo_mode) begin
            if (q.size() < DEPTH) begin
              q.push_back(cv);
              if (q.size() > HALF) m_dreq = 0;
              if (!fell && !shift_done) tag = "R3";
            end else if (!fell && !shift_done) tag = "R4";
          end else begin
            if (m_dreq) begin m_hold = cv; m_dreq = 0; end
            if (!fell && !shift_done) tag = "R5";
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (armed && !finished) begin
      checks++;
      if (tx_empty !== m_empty || data_req !== m_dreq || shift_load !== m_load ||
          (m_load && shift_data !== (DATA_W+1)'(m_data))) begin
        fails++;
        $display("FAIL %s cyc %0d: empty=%b dreq=%b load=%b data=%h expected empty=%b dreq=%b load=%b data=%h",
                 tag, cyc, tx_empty, data_req, shift_load, shift_data,
                 m_empty, m_dreq, m_load, m_data[DATA_W:0]);
      end
    end
  end

  task automatic step(input bit w, input int d, input bit done, input bit clr = 0);
    wr_en = w; wr_data = d[DATA_W-1:0]; shift_done = done; tx_clr = clr;
    @(negedge clk);
    wr_en = 0; shift_done = 0; tx_clr = 0;
  endtask

  task automatic report();
    finished = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 100000 && !finished) begin
      fails++; checks++;
      $display("FAIL watchdog: cycle %0d expected completion", cyc);
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;                                 // R1 reset state checked each cycle
    // holding mode: R2, R5, R7, R10
    step(1, 8'hA1, 0);
    step(1, 8'hB2, 0);
    step(1, 8'hC3, 0);                       // ignored, R5
    step(0, 0, 1);                           // hold -> shift, R7
    step(0, 0, 1);                           // empty, R7
    step(0, 0, 1);                           // idle done, R10
    // queue mode entered with clear, R1
    fifo_mode = 1; step(0, 0, 0, 1);
    for (int i = 0; i < DEPTH + 6; i++) step(1, i, 0);   // R3, R4
    for (int i = 0; i < DEPTH + 3; i++) step(0, 0, 1);   // R6
    // same-cycle done and write, R8
    step(1, 8'h11, 0); step(1, 8'h22, 0); step(1, 8'h33, 1); step(0, 0, 1); step(0, 0, 1);
    // break marker, R9
    brk_ctl = 1; step(0, 0, 0);
    brk_ctl = 0; step(1, 8'h55, 0);
    step(0, 0, 1); step(0, 0, 1);
    // clear priority, R11
    step(1, 8'h66, 0); step(1, 8'h77, 1, 1); step(0, 0, 1);
    // random traffic in both modes
    for (int m = 0; m < 4; m++) begin
      fifo_mode = m[0]; step(0, 0, 0, 1);
      for (int i = 0; i < 2500; i++) begin
        brk_ctl = ($urandom_range(0, 40) == 0) ? ~brk_ctl : brk_ctl;
        step(($urandom_range(0, 99) < 55), $urandom_range(0, 255),
             ($urandom_range(0, 99) < 45), ($urandom_range(0, 400) == 0));
      end
    end
    report();
  end
endmodule